// File: doc/BRIEF.md
# EEPROM Page Buffer Commit Engine

This block sits behind a serial-bus front-end in a small non-volatile memory model. The front-end hands it a starting word address, then a stream of data bytes, and finally a stop strobe. Bytes are not written to the array as they arrive. Instead they collect in a 16-entry page buffer, indexed by the low four bits of an internal pointer. Only when stop arrives are they copied into a 256-byte array, all in a single cycle.

The pointer advances only within its 16-byte page. Because of this, a long burst overwrites its own earlier bytes, and a burst that starts near the end of a page wraps back to the start of the same page. Each buffer slot carries a written flag. Only flagged slots reach the array, so untouched bytes in the page keep their old contents.

After a commit the block holds busy high for a fixed, parameterised number of cycles. All inputs are ignored while busy is high. A write-protect level blocks the array update but leaves the busy period unchanged. A combinational read port exposes the array for test.

Top module: `eeprom_page_commit`

## Requirements
- R1: After reset, busy is low and every array byte reads 0x00 on the read port. `rd_data` always shows the array byte at `rd_addr` combinationally.
- R2: An accepted `byte_valid` stores `byte_data` in the buffer slot selected by pointer bits [3:0]. It then increments those four bits modulo 16, and pointer bits [7:4] do not change.
- R3: If more than 16 bytes arrive before stop, a later byte replaces the earlier byte in the same slot. The array receives the last value written to each slot.
- R4: A burst that starts at address 0x3E wraps within its page. Its bytes land at 0x3E, 0x3F, 0x30, 0x31 and never reach 0x40.
- R5: The array does not change before stop. On an accepted stop, each flagged slot i is written to address {pointer[7:4], i}. Array bytes whose slots were not flagged keep their values.
- R6: An accepted stop with at least one flagged slot raises busy in the next cycle. Busy then stays high for exactly BUSY_CYCLES cycles.
- R7: If `wp` is high when stop is accepted, no array byte changes. Busy is still asserted for the full BUSY_CYCLES cycles.
- R8: An accepted stop with no flagged slot changes no array byte, and busy stays low.
- R9: While busy is high, `addr_load`, `byte_valid` and `stop` are all ignored. The pointer, the buffer and the flags keep their values.
- R10: When several inputs are high in one cycle, `addr_load` wins over `stop`, and `stop` wins over `byte_valid`. The losing inputs have no effect in that cycle.
- R11: An accepted address load clears all slot flags. A commit also clears all slot flags, so a second stop with no new bytes starts no write cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_load | input | 1 | Load `addr_in` into the pointer and clear the slot flags |
| addr_in | input | 8 | Starting word address |
| byte_valid | input | 1 | A data byte is presented this cycle |
| byte_data | input | 8 | Data byte |
| stop | input | 1 | End of transaction; commits the flagged slots |
| wp | input | 1 | Write-protect level, sampled when stop is accepted |
| busy | output | 1 | Write cycle in progress |
| rd_addr | input | 8 | Test read address |
| rd_data | output | 8 | Array byte at `rd_addr` |

## Verification
Stop can arrive in the same cycle as a data byte, and an address load can coincide with a byte. The bench raises both pairs together in one cycle and judges the outcome through the read port after the commit. A byte that coincides with stop must not appear in the array. A byte that coincides with an address load must not occupy slot 0 of the new page, and the next byte must land there instead. The every-cycle reference model applies the same priority, so any disagreement is caught on the clock where the array or busy diverges.

// File: rtl/eeprom_page_commit.sv
module eeprom_page_commit #(
  parameter int AW = 8,
  parameter int PW = 4,
  parameter int BUSY_CYCLES = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          addr_load,
  input  logic [AW-1:0] addr_in,
  input  logic          byte_valid,
  input  logic [7:0]    byte_data,
  input  logic          stop,
  input  logic          wp,
  output logic          busy,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);
  localparam int DEPTH = 1 << AW;
  localparam int PAGE  = 1 << PW;
  localparam int CW    = $clog2(BUSY_CYCLES + 1);

  logic [7:0]    mem  [DEPTH];
  logic [7:0]    pbuf [PAGE];
  logic [PAGE-1:0] mask;
  logic [AW-1:0] ptr;
  logic [CW-1:0] cnt;

  assign busy    = cnt != '0;
  assign rd_data = mem[rd_addr];

  wire load_go = !busy && addr_load;
  wire stop_go = !busy && !addr_load && stop;
  wire byte_go = !busy && !addr_load && !stop && byte_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      for (int i = 0; i < PAGE; i++) pbuf[i] <= '0;
      mask <= '0;
      ptr  <= '0;
      cnt  <= '0;
    end else if (busy) begin
      cnt <= cnt - 1'b1;
    end else if (load_go) begin
      ptr  <= addr_in;
      mask <= '0;
    end else if (stop_go) begin
      if (mask != '0) begin
        for (int i = 0; i < PAGE; i++)
          if (mask[i] && !wp) mem[{ptr[AW-1:PW], PW'(i)}] <= pbuf[i];
        cnt  <= CW'(BUSY_CYCLES);
        mask <= '0;
      end
    end else if (byte_go) begin
      pbuf[ptr[PW-1:0]] <= byte_data;
      mask[ptr[PW-1:0]] <= 1'b1;
      ptr[PW-1:0]       <= ptr[PW-1:0] + 1'b1;
    end
  end

  assert_page_fixed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    byte_go |=> ptr[AW-1:PW] == $past(ptr[AW-1:PW]) && mask != '0);

  assert_busy_after_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_go && mask != '0) |=> busy);

  assert_busy_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(cnt) == CW'(1));

  assert_wp_no_change_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_go && wp) |=> (rd_data == $past(rd_data) || rd_addr != $past(rd_addr)));

  assert_empty_stop_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_go && mask == '0) |=> !busy);

  assert_busy_holds_state_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(ptr) && $stable(mask));

  assert_load_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    load_go |=> mask == '0 && ptr == $past(addr_in));
endmodule

// File: tb/eeprom_page_commit_tb.sv
module eeprom_page_commit_tb_top;
  localparam int BC = 10;
  logic clk = 0, rst_n = 0;
  logic addr_load = 0, byte_valid = 0, stop = 0, wp = 0;
  logic [7:0] addr_in = 0, byte_data = 0, rd_addr = 0;
  logic busy;
  logic [7:0] rd_data;
  int errors = 0, checks = 0, cyc = 0;

  int mem_m [256];
  int buf_m [16];
  bit mask_m [16];
  int ptr_m = 0, cnt_m = 0;

  always #2 clk = ~clk;

  eeprom_page_commit #(.BUSY_CYCLES(BC)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .addr_in(addr_in),
    .byte_valid(byte_valid), .byte_data(byte_data), .stop(stop), .wp(wp),
    .busy(busy), .rd_addr(rd_addr), .rd_data(rd_data));

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic void model(bit al, int a, bit bv, int d, bit st);
    bit any = 0;
    if (cnt_m > 0) cnt_m--;
    else if (al) begin
      ptr_m = a;
      foreach (mask_m[i]) mask_m[i] = 0;
    end else if (st) begin
      foreach (mask_m[i]) any |= mask_m[i];
      if (any) begin
        for (int i = 0; i < 16; i++)
          if (mask_m[i] && !wp) mem_m[(ptr_m & 'hF0) | i] = buf_m[i];
        foreach (mask_m[i]) mask_m[i] = 0;
        cnt_m = BC;
      end
    end else if (bv) begin
      buf_m[ptr_m & 15] = d;
      mask_m[ptr_m & 15] = 1;
      ptr_m = (ptr_m & 'hF0) | ((ptr_m + 1) & 15);
    end
  endfunction

  task automatic step(bit al, int a, bit bv, int d, bit st);
    @(negedge clk);
    addr_load = al; addr_in = 8'(a); byte_valid = bv; byte_data = 8'(d); stop = st;
    rd_addr = 8'(cyc * 37);
    #1;
    check("R6 busy vs model", int'(busy), int'(cnt_m > 0));
    check("R5 array vs model", int'(rd_data), mem_m[rd_addr]);
    model(al, a, bv, d, st);
    cyc++;
  endtask

  task automatic load(int a);  step(1, a, 0, 0, 0); endtask
  task automatic send(int d);  step(0, 0, 1, d, 0); endtask
  task automatic fin();        step(0, 0, 0, 0, 1); endtask
  task automatic idle(int n);  for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0); endtask

  task automatic peek(int a, int exp, string tag);
    @(negedge clk);
    addr_load = 0; byte_valid = 0; stop = 0;
    rd_addr = 8'(a);
    #1;
    check(tag, int'(rd_data), exp);
    model(0, 0, 0, 0, 0);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    foreach (mem_m[i]) mem_m[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    #1 check("R1 reset busy", int'(busy), 0);
    peek(8'h00, 0, "R1 reset array 00");
    peek(8'hFF, 0, "R1 reset array FF");

    load('h10); send('hAA); send('hBB);
    peek('h10, 0, "R5 no write before stop");
    fin(); idle(BC + 2);
    peek('h10, 'hAA, "R2 first byte");
    peek('h11, 'hBB, "R2 second byte");
    peek('h12, 0, "R5 unflagged slot untouched");

    load('h20);
    for (int i = 1; i <= 17; i++) send(i);
    fin(); idle(BC + 2);
    peek('h20, 'h11, "R3 overwrite slot 0");
    peek('h21, 'h02, "R3 slot 1 kept");
    peek('h2F, 'h10, "R3 slot 15");

    load('h3E); send('hC1); send('hC2); send('hC3); send('hC4);
    fin(); idle(BC + 2);
    peek('h3E, 'hC1, "R4 3E");
    peek('h3F, 'hC2, "R4 3F");
    peek('h30, 'hC3, "R4 wrap 30");
    peek('h31, 'hC4, "R4 wrap 31");
    peek('h40, 0, "R4 next page untouched");

    wp = 1;
    load('h50); send('h77); fin();
    n = 0;
    for (int i = 0; i < BC + 4; i++) begin
      step(0, 0, 0, 0, 0);
      if (busy) n++;
    end
    check("R7 busy length under wp", n, BC);
    wp = 0;
    peek('h50, 0, "R7 protected byte unchanged");

    load('h60); fin();
    #1 check("R8 empty stop no busy", int'(busy), 0);
    idle(2);

    load('h70); send('h11); fin();
    send('h99); load('h80); fin();
    idle(BC + 2);
    peek('h71, 0, "R9 byte during busy ignored");
    send('h22); fin(); idle(BC + 2);
    peek('h71, 'h22, "R9 pointer kept through busy");
    peek('h70, 'h11, "R11 old slot not rewritten");

    step(1, 'h90, 1, 'h55, 0);
    send('h33);
    step(0, 0, 1, 'h44, 1);
    idle(BC + 2);
    peek('h90, 'h33, "R10 load beats byte");
    peek('h91, 0, "R10 stop beats byte");

    fin();
    #1 check("R11 repeat stop no busy", int'(busy), 0);
    idle(3);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule